// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

A shared unit through which any of `NCORE` cores raises an interrupt on any other core (or on itself) and through which the interrupted core learns who raised it. Cores talk to the unit through one command port that takes one command per cycle. Each command carries an operation code, the identity of the calling core, and one core-number argument. Query results come back on a registered readback bus. Each core has one interrupt output.

The unit stores one pending bit for every sender/target pair. When several senders signal the same target, that target sees a single interrupt line. It asks for the vector of sources, which may have more than one bit set, and acknowledges each sender with its own command. A sender checks whether its previous interrupt to a target is still outstanding before it raises a new one.

Operation codes on `cmd_op` are: 0 no operation, 1 raise, 2 status query, 3 source query, 4 acknowledge. Codes 5 to 7 do nothing.

Top module: `ipi_unit`

## Requirements
- R1: A synchronous active-high `rst` clears every pending bit. After it, `irq` and `rdback` are all zero.
- R2: A raise (code 1) from caller c with argument t sets pending bit (c,t). `irq[t]` is high from the cycle after the strobe.
- R3: A raise toward a pair that is already pending changes nothing. A single acknowledge still clears that pair.
- R4: A status query (code 2) from caller c with argument t puts pending bit (c,t) on `rdback[0]` and zero on the upper bits. The result appears in the cycle after the strobe.
- R5: A source query (code 3) from caller c returns a vector on `rdback` in the cycle after the strobe. Bit i of that vector is pending bit (i,c).
- R6: An acknowledge (code 4) from caller c with argument s clears only pending bit (s,c). Every other pair keeps its value.
- R7: `irq[t]` is the OR of all pending bits (i,t). It stays high while any of those bits is set and drops in the cycle after the last acknowledge.
- R8: `rdback` keeps the result of the most recent query until the next query. Raise, acknowledge, no-operation and the unused codes leave it unchanged.
- R9: A cycle with `cmd_valid` low, or with an unused opcode, changes neither the pending state nor any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Operation code |
| cmd_caller | input | IDW | Identity of the calling core |
| cmd_arg | input | IDW | Core-number argument (target or sender) |
| rdback | output | NCORE | Registered query result |
| irq | output | NCORE | Interrupt line per core |

## Verification
A wrong pending bit shows up on the target's `irq` line one cycle after the command that corrupted it. It also shows up on `rdback` in the cycle after the next status or source query that touches that pair. The bench keeps its own sender/target matrix and compares both output buses after every command. A pending bit that is lost, duplicated, cleared for the wrong pair or stuck is therefore reported at the first command that follows it. The sweep covers every pair singly, all pairs set at once, and a long pseudo-random command stream.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_RAISE   = 3'd1,
        OP_STATUS  = 3'd2,
        OP_SOURCES = 3'd3,
        OP_ACK     = 3'd4
    } ipi_op_e;

    typedef struct packed {
        logic raise;
        logic status;
        logic sources;
        logic ack;
    } ipi_act_t;

    function automatic ipi_act_t ipi_decode_op(input logic valid, input logic [2:0] op);
        ipi_act_t a;
        a = '0;
        if (valid) begin
            case (op)
                OP_RAISE:   a.raise   = 1'b1;
                OP_STATUS:  a.status  = 1'b1;
                OP_SOURCES: a.sources = 1'b1;
                OP_ACK:     a.ack     = 1'b1;
                default:    a = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int IDW   = 2
) (
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [IDW-1:0] cmd_caller,
    input  logic [IDW-1:0] cmd_arg,
    output ipi_act_t       act
);
    logic ids_ok;

    // Core numbers at or above NCORE are dropped.
    assign ids_ok = (32'(cmd_caller) < NCORE) && (32'(cmd_arg) < NCORE);

    always_comb begin
        act = ipi_decode_op(cmd_valid && ids_ok, cmd_op);
    end
endmodule

// File: rtl/ipi_matrix.sv
module ipi_matrix #(
    parameter int NCORE = 4,
    parameter int IDW   = 2,
    localparam int CELLS = NCORE * NCORE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_raise,
    input  logic             do_ack,
    input  logic [IDW-1:0]   caller,
    input  logic [IDW-1:0]   arg,
    output logic [CELLS-1:0] pend,
    output logic [NCORE-1:0] irq
);
    // Cell s*NCORE+t is the pending bit from sender s toward target t.
    for (genvar s = 0; s < NCORE; s++) begin : g_snd
        for (genvar t = 0; t < NCORE; t++) begin : g_tgt
            logic hit_set, hit_clr;
            assign hit_set = do_raise && (caller == IDW'(s)) && (arg == IDW'(t));
            assign hit_clr = do_ack   && (arg == IDW'(s)) && (caller == IDW'(t));
            always_ff @(posedge clk) begin
                if (rst)
                    pend[s*NCORE+t] <= 1'b0;
                else if (hit_set)
                    pend[s*NCORE+t] <= 1'b1;
                else if (hit_clr)
                    pend[s*NCORE+t] <= 1'b0;
            end
        end
    end

    // Each target's line merges all of its senders.
    for (genvar t = 0; t < NCORE; t++) begin : g_line
        logic [NCORE-1:0] col;
        for (genvar s = 0; s < NCORE; s++) begin : g_col
            assign col[s] = pend[s*NCORE+t];
        end
        assign irq[t] = |col;
    end
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
    parameter int NCORE = 4,
    parameter int IDW   = 2,
    localparam int CELLS = NCORE * NCORE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_status,
    input  logic             q_sources,
    input  logic [IDW-1:0]   caller,
    input  logic [IDW-1:0]   arg,
    input  logic [CELLS-1:0] pend,
    output logic [NCORE-1:0] rdback
);
    logic [NCORE-1:0] src_vec;
    logic [NCORE-1:0] stat_vec;

    always_comb begin
        src_vec  = '0;
        stat_vec = '0;
        for (int i = 0; i < NCORE; i++) begin
            for (int j = 0; j < NCORE; j++) begin
                if (caller == IDW'(j)) src_vec[i] = pend[i*NCORE+j];
                if (caller == IDW'(i) && arg == IDW'(j)) stat_vec[0] = pend[i*NCORE+j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdback <= '0;
        else if (q_status)
            rdback <= stat_vec;
        else if (q_sources)
            rdback <= src_vec;
    end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int IDW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDW-1:0]   cmd_caller,
    input  logic [IDW-1:0]   cmd_arg,
    output logic [NCORE-1:0] rdback,
    output logic [NCORE-1:0] irq
);
    localparam int CELLS = NCORE * NCORE;

    ipi_act_t         act;
    logic [CELLS-1:0] pend;

    ipi_decode #(.NCORE(NCORE), .IDW(IDW)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_caller(cmd_caller),
        .cmd_arg   (cmd_arg),
        .act       (act)
    );

    ipi_matrix #(.NCORE(NCORE), .IDW(IDW)) u_mat (
        .clk     (clk),
        .rst     (rst),
        .do_raise(act.raise),
        .do_ack  (act.ack),
        .caller  (cmd_caller),
        .arg     (cmd_arg),
        .pend    (pend),
        .irq     (irq)
    );

    ipi_readback #(.NCORE(NCORE), .IDW(IDW)) u_rb (
        .clk      (clk),
        .rst      (rst),
        .q_status (act.status),
        .q_sources(act.sources),
        .caller   (cmd_caller),
        .arg      (cmd_arg),
        .pend     (pend),
        .rdback   (rdback)
    );
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
    parameter int NCORE = 4,
    parameter int IDW   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [IDW-1:0]   cmd_caller,
    input logic [IDW-1:0]   cmd_arg,
    input logic [NCORE-1:0] rdback,
    input logic [NCORE-1:0] irq
);
    logic is_raise, is_query, is_ack;
    assign is_raise = cmd_valid && cmd_op == 3'd1;
    assign is_query = cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3);
    assign is_ack   = cmd_valid && cmd_op == 3'd4;

    a_r1_reset_clear: assert property (@(posedge clk)
        $fell(rst) |-> (irq == '0 && rdback == '0));

    a_r2_raise_line: assert property (@(posedge clk) disable iff (rst)
        is_raise |=> irq[$past(cmd_arg)]);

    a_r2_one_new_line: assert property (@(posedge clk) disable iff (rst)
        $countones(irq & ~$past(irq)) <= 1);

    a_r7_rise_needs_raise: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~$past(irq)) != '0) |-> $past(is_raise));

    a_r6_drop_needs_ack: assert property (@(posedge clk) disable iff (rst)
        ((~irq & $past(irq)) != '0) |-> ($past(is_ack) && $onehot(~irq & $past(irq))));

    a_r4_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd2) |=> (rdback[NCORE-1:1] == '0));

    a_r8_readback_hold: assert property (@(posedge clk) disable iff (rst)
        !is_query |=> $stable(rdback));

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(irq) && $stable(rdback)));
endmodule

bind ipi_unit ipi_unit_chk #(.NCORE(NCORE), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_caller(cmd_caller),
    .cmd_arg   (cmd_arg),
    .rdback    (rdback),
    .irq       (irq)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid;
    logic [2:0]   cmd_op;
    logic [W-1:0] cmd_caller, cmd_arg;
    logic [N-1:0] rdback, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit           mp [N][N];
    logic [N-1:0] m_rd;

    always #2 clk = ~clk;

    ipi_unit #(.NCORE(N)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_caller(cmd_caller), .cmd_arg(cmd_arg), .rdback(rdback), .irq(irq)
    );

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] v = '0;
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++)
                if (mp[s][t]) v[t] = 1'b1;
        return v;
    endfunction

    function automatic string tag(input logic v, input logic [2:0] op);
        if (!v) return "R9 idle";
        case (op)
            3'd1: return "R2/R3 raise";
            3'd2: return "R4 status";
            3'd3: return "R5 sources";
            3'd4: return "R6/R7 ack";
            default: return "R9/R8 unused op";
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge and checks.
    task automatic cmd(input logic v, input logic [2:0] op, input int c, input int a);
        cmd_valid  = v;
        cmd_op     = op;
        cmd_caller = W'(c);
        cmd_arg    = W'(a);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (v) begin
            case (op)
                3'd1: mp[c][a] = 1'b1;
                3'd2: m_rd = {{(N-1){1'b0}}, mp[c][a]};
                3'd3: for (int i = 0; i < N; i++) m_rd[i] = mp[i][c];
                3'd4: mp[a][c] = 1'b0;
                default: ;
            endcase
        end
        check({tag(v, op), " irq"}, irq, exp_irq());
        check({tag(v, op), " rdback"}, rdback, m_rd);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++) mp[s][t] = 1'b0;
        m_rd = '0;
        check("R1 reset irq", irq, '0);
        check("R1 reset rdback", rdback, '0);
    endtask

    initial begin
        #(4ns * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        cmd_valid = 0; cmd_op = 0; cmd_caller = 0; cmd_arg = 0; rst = 1;
        @(negedge clk);
        do_reset();

        // Every pair on its own: raise, status, sources, re-raise, ack, status.
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                cmd(1, 3'd1, s, t);
                cmd(1, 3'd2, s, t);
                cmd(1, 3'd3, t, 0);
                cmd(1, 3'd1, s, t);
                cmd(1, 3'd0, s, t);
                cmd(1, 3'd4, t, s);
                cmd(1, 3'd2, s, t);
                cmd(1, 3'd3, t, 0);
            end
        end

        // All pairs pending, then acknowledge one sender at a time (R6, R7).
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++) cmd(1, 3'd1, s, t);
        cmd(1, 3'd1, 2, 1);
        for (int t = 0; t < N; t++) begin
            cmd(1, 3'd3, t, 0);
            for (int s = 0; s < N; s++) begin
                cmd(1, 3'd4, t, s);
                cmd(1, 3'd3, t, 0);
                cmd(1, 3'd2, s, t);
                cmd(0, 3'd1, s, t);
            end
        end

        // Readback survives a reset request only as zero (R1).
        cmd(1, 3'd1, 1, 3);
        cmd(1, 3'd3, 3, 0);
        do_reset();
        cmd(1, 3'd3, 3, 0);

        // Pseudo-random stream including idle cycles and unused codes.
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cmd(lfsr[0] | lfsr[1], lfsr[4:2] % 3'd6 == 3'd5 ? lfsr[4:2] : 3'(lfsr[4:2] % 3'd5),
                int'(lfsr[6:5]), int'(lfsr[8:7]));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule